// File: doc/BRIEF.md
# Address-as-Data Memory Test Engine

This block exercises a word-wide memory through a simple request port. After a start pulse it runs three phases in turn. In the fill phase every word of a source region is written with its own byte address and then read back at once. In the copy phase each source word is read and written to the matching word of a destination region. In the verify phase each destination word is read and compared with the address of the source word it came from. The memory port carries one request per cycle at most and keeps only one read in flight. A read completes when the memory raises its read-valid strobe.

The engine stops at the first mismatch. It raises a fail flag and holds the failing address, the expected word and the observed word until the next start. A run that completes with no mismatch ends with done and pass high. Region bases, word count and read latency are all chosen at run time. Address, data and count widths are parameters.

Top module: `addr_data_mem_tester`

## Requirements
- R1: During the fill phase, word i of the source region is written at byte address `src_base + 4*i`, with data equal to that address zero-extended to the data width.
- R2: Each fill write is followed in the very next cycle by a read request to the same address. The returned word is compared before the next source address is written.
- R3: The copy phase starts only after all source words have been written. Each source word i is read, and the returned data is written to `dst_base + 4*i`. Nothing is written beyond the destination region.
- R4: In the verify phase each destination word i is read and compared with `src_base + 4*i`.
- R5: A new request is never issued while a read is waiting for its read-valid strobe.
- R6: On the first mismatch the engine stops issuing requests and drives fail=1, done=1 and pass=0. It holds the read address, the expected word and the returned word on fail_addr, fail_exp and fail_obs until the next accepted start.
- R7: A run of N words with read latency L cycles (the strobe arrives L cycles after the request edge, L ≥ 1) with no mismatch raises done=1 and pass=1 exactly N*(5+3L) cycles after the clock edge that accepts start.
- R8: A start with word_count = 0 gives done=1 and pass=1 in the cycle right after the accepting edge, and no memory request is made.
- R9: A start pulse that arrives while the engine is busy is ignored. The run in progress keeps its timing and its result.
- R10: While reset is held and after its release, mem_req, busy, done, pass and fail are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; accepted only when not busy |
| src_base | input | AW | Byte address of the source region (word aligned) |
| dst_base | input | AW | Byte address of the destination region (word aligned) |
| word_count | input | CW | Number of words per region |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended (pass or fail) |
| pass | output | 1 | Run ended without mismatch |
| fail | output | 1 | Run stopped on a mismatch |
| fail_addr | output | AW | Address of the failing read |
| fail_exp | output | DW | Expected word at the failure |
| fail_obs | output | DW | Returned word at the failure |

## Verification
Each result has a fixed arrival time. A passing run completes N*(5+3L) cycles after the accepting edge. A fill-phase fault at word j appears after (j+1)*(2+L) cycles. A verify-phase fault at word j appears after 2N*(2+L)+(j+1)*(1+L) cycles. A zero-length start completes after exactly one edge. The bench counts falling edges from the accepting edge until done rises and compares that count with these formulas for read latencies 1 to 3. It samples every output at the falling edge, half a period after the register that drives it has updated.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FWR,   // fill: write word
      ST_FRD,   // fill: read back
      ST_FWT,   // fill: wait for data
      ST_CRD,   // copy: read source
      ST_CWT,   // copy: wait for data
      ST_CWR,   // copy: write destination
      ST_VRD,   // verify: read destination
      ST_VWT,   // verify: wait for data
      ST_DONE,
      ST_FAIL
   } mt_state_e;
endpackage

// File: rtl/memtest_idx.sv
module memtest_idx #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [CW-1:0] idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (clr) idx <= '0;
      else if (adv) idx <= idx + 1'b1;
   end
endmodule

// File: rtl/memtest_cmp.sv
module memtest_cmp #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          chk,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] exp_w,
   input  logic [DW-1:0] obs_w,
   output logic          mismatch,
   output logic [AW-1:0] f_addr,
   output logic [DW-1:0] f_exp,
   output logic [DW-1:0] f_obs
);
   assign mismatch = (obs_w != exp_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_addr <= '0;
         f_exp  <= '0;
         f_obs  <= '0;
      end else if (clr) begin
         f_addr <= '0;
         f_exp  <= '0;
         f_obs  <= '0;
      end else if (chk && mismatch) begin
         f_addr <= addr;
         f_exp  <= exp_w;
         f_obs  <= obs_w;
      end
   end
endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
   import memtest_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      acc,
   input  logic      zero_len,
   input  logic      rvalid,
   input  logic      mismatch,
   input  logic      last,
   output mt_state_e st,
   output logic      idx_clr,
   output logic      idx_adv
);
   mt_state_e nx;

   always_comb begin
      nx      = st;
      idx_clr = 1'b0;
      idx_adv = 1'b0;
      if (acc) begin
         idx_clr = 1'b1;
         nx      = zero_len ? ST_DONE : ST_FWR;
      end else begin
         case (st)
            ST_FWR: nx = ST_FRD;
            ST_FRD: nx = ST_FWT;
            ST_FWT: if (rvalid) begin
               if (mismatch)  nx = ST_FAIL;
               else if (last) begin nx = ST_CRD; idx_clr = 1'b1; end
               else           begin nx = ST_FWR; idx_adv = 1'b1; end
            end
            ST_CRD: nx = ST_CWT;
            ST_CWT: if (rvalid) nx = ST_CWR;
            ST_CWR: if (last) begin nx = ST_VRD; idx_clr = 1'b1; end
                    else      begin nx = ST_CRD; idx_adv = 1'b1; end
            ST_VRD: nx = ST_VWT;
            ST_VWT: if (rvalid) begin
               if (mismatch)  nx = ST_FAIL;
               else if (last) nx = ST_DONE;
               else           begin nx = ST_VRD; idx_adv = 1'b1; end
            end
            default: nx = st;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= nx;
   end
endmodule

// File: rtl/addr_data_mem_tester.sv
module addr_data_mem_tester
   import memtest_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] src_base,
   input  logic [AW-1:0] dst_base,
   input  logic [CW-1:0] word_count,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_rvalid,
   output logic          busy,
   output logic          done,
   output logic          pass,
   output logic          fail,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_exp,
   output logic [DW-1:0] fail_obs
);
   localparam int IW = CW + 2;

   generate
      if (AW > DW) begin : g_bad_width
         $error("data width must hold a full address");
      end
      if (AW < 3) begin : g_bad_aw
         $error("address width too small for word stepping");
      end
      if (CW < 1) begin : g_bad_cw
         $error("count width must be at least 1");
      end
   endgenerate

   mt_state_e     st;
   logic          acc, idx_clr, idx_adv, last, mismatch, chk;
   logic [CW-1:0] idx, cnt_q;
   logic [AW-1:0] src_q, dst_q, off, src_a, dst_a, cmp_addr;
   logic [IW-1:0] stride;
   logic [DW-1:0] src_exp, copy_q;

   assign busy = (st != ST_IDLE) && (st != ST_DONE) && (st != ST_FAIL);
   assign acc  = start && !busy;
   assign done = (st == ST_DONE) || (st == ST_FAIL);
   assign pass = (st == ST_DONE);
   assign fail = (st == ST_FAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         cnt_q <= '0;
      end else if (acc) begin
         src_q <= src_base;
         dst_q <= dst_base;
         cnt_q <= word_count;
      end
   end

   memtest_idx #(.CW(CW)) u_idx (
      .clk(clk), .rst_n(rst_n), .clr(idx_clr), .adv(idx_adv), .idx(idx)
   );

   assign last   = (idx == cnt_q - 1'b1);
   assign stride = {idx, 2'b00};

   generate
      if (IW >= AW) begin : g_off_trunc
         assign off = stride[AW-1:0];
      end else begin : g_off_ext
         assign off = {{(AW-IW){1'b0}}, stride};
      end
      if (DW == AW) begin : g_exp_same
         assign src_exp = src_a;
      end else begin : g_exp_ext
         assign src_exp = {{(DW-AW){1'b0}}, src_a};
      end
   endgenerate

   assign src_a = src_q + off;
   assign dst_a = dst_q + off;

   memtest_seq u_seq (
      .clk(clk), .rst_n(rst_n), .acc(acc), .zero_len(word_count == '0),
      .rvalid(mem_rvalid), .mismatch(mismatch), .last(last),
      .st(st), .idx_clr(idx_clr), .idx_adv(idx_adv)
   );

   assign chk      = mem_rvalid && ((st == ST_FWT) || (st == ST_VWT));
   assign cmp_addr = (st == ST_VWT) ? dst_a : src_a;

   memtest_cmp #(.AW(AW), .DW(DW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clr(acc), .chk(chk), .addr(cmp_addr),
      .exp_w(src_exp), .obs_w(mem_rdata), .mismatch(mismatch),
      .f_addr(fail_addr), .f_exp(fail_exp), .f_obs(fail_obs)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         copy_q <= '0;
      else if (st == ST_CWT && mem_rvalid) copy_q <= mem_rdata;
   end

   assign mem_req   = (st == ST_FWR) || (st == ST_FRD) || (st == ST_CRD) ||
                      (st == ST_CWR) || (st == ST_VRD);
   assign mem_we    = (st == ST_FWR) || (st == ST_CWR);
   assign mem_addr  = ((st == ST_CWR) || (st == ST_VRD)) ? dst_a : src_a;
   assign mem_wdata = (st == ST_CWR) ? copy_q : src_exp;

   // ---------------- checks ----------------
   logic          rd_pend;
   logic [DW-1:0] last_rd;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         last_rd <= '0;
      end else begin
         if (mem_rvalid)                rd_pend <= 1'b0;
         else if (mem_req && !mem_we)   rd_pend <= 1'b1;
         if (mem_rvalid)                last_rd <= mem_rdata;
      end
   end

   // R5
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pend |-> !mem_req);
   // R2
   readback_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && st == ST_FWR) |=>
      (mem_req && !mem_we && mem_addr == $past(mem_addr)));
   // R1
   fill_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && st != ST_CWR) |-> (mem_wdata[AW-1:0] == mem_addr));
   // R3
   copy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && st == ST_CWR) |-> (mem_wdata == last_rd));
   // R6
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_exp) &&
                            $stable(fail_obs)));
   // R6
   quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);
   // R8
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && word_count == '0) |=> (done && pass));
endmodule

// File: tb/sim_addr_data_mem_tester.sv
module sim_addr_data_mem_tester;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int CW = 6;
   localparam time TCLK = 10ns;
   localparam logic [DW-1:0] BG = 16'hA5A5;
   localparam logic [DW-1:0] FMASK = 16'h0040;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [AW-1:0] src_base = '0, dst_base = '0;
   logic [CW-1:0] word_count = '0;
   logic mem_req, mem_we, mem_rvalid, busy, done, pass, fail;
   logic [AW-1:0] mem_addr, fail_addr;
   logic [DW-1:0] mem_wdata, mem_rdata, fail_exp, fail_obs;

   int checks = 0, failures = 0, lat = 1, wd = 0;
   logic fault_en = 1'b0;
   logic [AW-1:0] fault_addr = '0;

   always #(TCLK/2) clk = ~clk;

   addr_data_mem_tester #(.AW(AW), .DW(DW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
      .dst_base(dst_base), .word_count(word_count), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .busy(busy),
      .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr),
      .fail_exp(fail_exp), .fail_obs(fail_obs));

   // memory model with read latency lat
   logic [DW-1:0] mem [0:1023];
   logic pend = 1'b0;
   int lcnt = 0;
   logic [AW-1:0] raddr = '0;
   assign mem_rvalid = pend && (lcnt == 0);
   assign mem_rdata  = mem[raddr[11:2]];

   always @(posedge clk) begin
      if (mem_req && mem_we)
         mem[mem_addr[11:2]] <= mem_wdata ^ ((fault_en && mem_addr == fault_addr) ? FMASK : '0);
      if (pend && lcnt == 0) pend <= 1'b0;
      else if (pend)         lcnt <= lcnt - 1;
      else if (mem_req && !mem_we) begin
         pend <= 1'b1; lcnt <= lat - 1; raddr <= mem_addr;
      end
   end

   // request monitor, sampled at falling edges
   int n_cur = 0, src_wr = 0, v_rb = 0, v_out = 0, v_ord = 0, v_end = 0;
   logic prev_fw = 1'b0;
   logic [AW-1:0] prev_a = '0, src_cur = '0, dst_cur = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_fw && !(mem_req && !mem_we && mem_addr == prev_a)) v_rb++;
         prev_fw = 1'b0;
         if (mem_req && pend) v_out++;
         if (mem_req && done) v_end++;
         if (mem_req && mem_we) begin
            if (mem_addr >= src_cur && mem_addr < src_cur + AW'(4*n_cur)) begin
               src_wr++; prev_fw = 1'b1; prev_a = mem_addr;
            end else if (src_wr < n_cur) v_ord++;
         end
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected<150000", wd);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 1024; i++) mem[i] = BG;
   endtask

   task automatic run(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n,
                      input bit poke, output int cyc);
      clear_mem();
      n_cur = n; src_cur = s; dst_cur = d;
      src_wr = 0; v_rb = 0; v_out = 0; v_ord = 0; v_end = 0;
      @(negedge clk);
      src_base = s; dst_base = d; word_count = CW'(n); start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 3) begin
            start = 1'b1; word_count = CW'(1); src_base = d;
         end else start = 1'b0;
      end
   endtask

   initial begin
      int cyc;
      int exp_c;
      int bad;
      logic [AW-1:0] fa0;
      clear_mem();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!mem_req && !busy && !done && !pass && !fail, "R10 in reset",
          {mem_req, busy, done, pass, fail}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_req && !busy && !done && !pass && !fail, "R10 after reset",
          {mem_req, busy, done, pass, fail}, 0);

      // sweep of latency, length and region placement
      for (int l = 1; l <= 3; l++) begin
         for (int k = 0; k < 5; k++) begin
            for (int b = 0; b < 2; b++) begin
               int n;
               logic [AW-1:0] s, d;
               n = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : 17;
               s = (b == 0) ? 12'h100 : 12'h3C0;
               d = (b == 0) ? 12'h800 : 12'hC04;
               lat = l;
               run(s, d, n, 1'b0, cyc);
               exp_c = n * (5 + 3 * l);
               if (n == 0) begin
                  // R8
                  chk(cyc == 0 && pass && !fail, "R8 zero length", cyc, 0);
                  chk(src_wr == 0 && v_end == 0, "R8 no requests", src_wr, 0);
               end else begin
                  // R7
                  chk(cyc == exp_c, "R7 cycle count", cyc, exp_c);
                  chk(done && pass && !fail, "R7 pass status", {done, pass, fail}, 3'b110);
               end
               bad = 0;
               for (int i = 0; i < n; i++) begin
                  logic [DW-1:0] e;
                  e = DW'(s + AW'(4 * i));
                  if (mem[(s >> 2) + i] != e) bad++;   // R1
                  if (mem[(d >> 2) + i] != e) bad++;   // R3, R4
               end
               chk(bad == 0, "R1 R3 region contents", bad, 0);
               chk(mem[(d >> 2) + n] == BG, "R3 no write past destination",
                   mem[(d >> 2) + n], BG);
               chk(src_wr == n, "R1 fill write count", src_wr, n);
               chk(v_rb == 0, "R2 readback follows write", v_rb, 0);
               chk(v_out == 0, "R5 single outstanding read", v_out, 0);
               chk(v_ord == 0, "R3 copy after fill", v_ord, 0);
            end
         end
      end

      // R9 start while busy is ignored
      lat = 2;
      run(12'h200, 12'h900, 6, 1'b1, cyc);
      chk(cyc == 6 * 11, "R9 busy start ignored timing", cyc, 66);
      chk(pass && !fail, "R9 busy start ignored result", {pass, fail}, 2'b10);
      chk(mem[(12'h900 >> 2) + 5] == 16'h0214, "R9 run kept its regions",
          mem[(12'h900 >> 2) + 5], 16'h0214);

      // R6 fault in the source region, caught at its read-back
      for (int l = 1; l <= 3; l++) begin
         lat = l;
         fault_en = 1'b1; fault_addr = 12'h10C;
         run(12'h100, 12'h800, 8, 1'b0, cyc);
         exp_c = 4 * (2 + l);
         chk(cyc == exp_c, "R2 R6 fill fault timing", cyc, exp_c);
         chk(fail && done && !pass, "R6 fail flags", {fail, done, pass}, 3'b110);
         chk(fail_addr == 12'h10C, "R6 fill fail addr", fail_addr, 12'h10C);
         chk(fail_exp == 16'h010C, "R6 fill fail exp", fail_exp, 16'h010C);
         chk(fail_obs == 16'h014C, "R6 fill fail obs", fail_obs, 16'h014C);
         chk(src_wr == 4, "R2 stopped before next write", src_wr, 4);
      end

      // R4 R6 fault in the destination region, caught in verify
      lat = 2;
      fault_addr = 12'h814;
      run(12'h100, 12'h800, 8, 1'b0, cyc);
      exp_c = 16 * 4 + 6 * 3;
      chk(cyc == exp_c, "R4 verify fault timing", cyc, exp_c);
      chk(fail && !pass, "R4 verify fault flags", {fail, pass}, 2'b10);
      chk(fail_addr == 12'h814, "R4 verify fail addr", fail_addr, 12'h814);
      chk(fail_exp == 16'h0114, "R4 verify fail exp", fail_exp, 16'h0114);
      chk(fail_obs == 16'h0154, "R4 verify fail obs", fail_obs, 16'h0154);
      fa0 = fail_addr;
      repeat (10) @(negedge clk);
      chk(v_end == 0, "R6 no requests after fail", v_end, 0);
      chk(fail && fail_addr == fa0, "R6 fail record held", fail_addr, fa0);
      fault_en = 1'b0;

      // a fresh start clears the fail record and passes
      run(12'h100, 12'h800, 3, 1'b0, cyc);
      chk(pass && !fail && fail_addr == '0, "R6 cleared on new start",
          {pass, fail}, 2'b10);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule